// File: doc/BRIEF.md
# Debug Status Word with Transition Messages

This block turns a processor's synchronous debug and power-state indicators into a registered, read-only 32-bit status word. The word holds a debug-mode flag, a three-bit system low-power field, a two-bit CPU low-power code and a checkstop flag. All remaining bits read as zero. A debug controller can read the word at any time. The read is a plain combinational view of the register, so reading changes nothing.

Alongside the register, the block produces messages for an external debug port. A message is raised when the debug flag changes in either direction. A message is also raised when either low-power field leaves its all-zero run value. Leaving low power for run mode raises no message, and neither does a change from one nonzero low-power value to another. The message payload is the top seven bits of the status word as it stands after the triggering update. The block holds one message at a time. A message stays valid until the consumer accepts it. A newer trigger overwrites a message that has not yet been taken.

Top module: `dbgstat_top`

## Requirements
- R1: Bit 31 of the status word is 1 exactly when the debug-mode input was high at the previous rising clock edge.
- R2: Status bit 28 follows the doze input, bit 29 follows the nap input and bit 30 follows the sleep input, each registered on the clock edge and each independent of the others.
- R3: Status bits 27:26 encode the CPU state as follows: 00 when none of the three CPU inputs is active, 01 for halted, 10 for stopped and 11 for waiting. When several are active, waiting wins over stopped, and stopped wins over halted.
- R4: Status bit 25 follows the checkstop input, registered on the clock edge.
- R5: Status bits 24:0 always read as zero. After a synchronous reset, the whole word and the message valid flag are zero.
- R6: While the read strobe is high, the read data equals the status word. While the strobe is low, the read data is zero. The strobe has no effect on the status word or on messages.
- R7: Every change of the debug flag in either direction raises a message in the same cycle as the status word shows the change.
- R8: A message is raised when the system low-power field or the CPU low-power field goes from all zeros to nonzero. No message is raised for a return to zero, for a change between nonzero values, or for a change of the checkstop flag alone.
- R9: A raised message keeps its valid flag high until a cycle in which valid and ready are both high. After that cycle, valid drops unless a new trigger occurs in the same cycle.
- R10: The payload is status bits 31:25 as they stand after the triggering update, in that order with bit 31 as the payload MSB. A trigger that arrives while a message is pending replaces the payload with the newer bits.
- R11: When a trigger and an acceptance happen in the same cycle, valid stays high and the payload carries the new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode_i | input | 1 | CPU is in debug mode |
| sys_doze_i | input | 1 | System doze mode |
| sys_nap_i | input | 1 | System nap mode |
| sys_sleep_i | input | 1 | System sleep mode |
| cpu_halted_i | input | 1 | CPU halted |
| cpu_stopped_i | input | 1 | CPU stopped |
| cpu_waiting_i | input | 1 | CPU waiting |
| cpu_chkstop_i | input | 1 | CPU checkstop |
| rd_en_i | input | 1 | Read strobe for the status word |
| rd_data_o | output | 32 | Status word while strobed, else zero |
| msg_valid_o | output | 1 | A status message is pending |
| msg_ready_i | input | 1 | Consumer accepts the pending message |
| msg_payload_o | output | 7 | Status bits 31:25 at the last trigger |

## Verification
Every state input reaches the status word one clock edge after it is applied. The message that the input change causes appears on that same edge, so a stimulus and its message are both due exactly one cycle later. The read data is combinational from the register and the strobe, so it is valid in the cycle the strobe is applied. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares every output against its behavioural model at the next falling edge, which lines each check up with that one-edge latency. Directed sequences with literal expected values cover the encoding priority, entry versus exit, overwrite and the same-cycle accept-and-trigger case.

// File: rtl/dbgstat_pkg.sv
package dbgstat_pkg;

    localparam int WORD_W = 32;
    localparam int SYS_W  = 3;
    localparam int CPU_W  = 2;
    localparam int MSG_W  = 1 + SYS_W + CPU_W + 1;
    localparam int RSVD_W = WORD_W - MSG_W;

    typedef enum logic [CPU_W-1:0] {
        CPU_RUN     = 2'b00,
        CPU_HALTED  = 2'b01,
        CPU_STOPPED = 2'b10,
        CPU_WAITING = 2'b11
    } cpu_lp_e;

    // Field order is behaviour: the message is the top MSG_W bits of this word.
    typedef struct packed {
        logic              dbg;
        logic [SYS_W-1:0]  sys_lp;   // [2]=sleep [1]=nap [0]=doze
        cpu_lp_e           cpu_lp;
        logic              chk;
        logic [RSVD_W-1:0] rsvd;
    } status_t;

    function automatic cpu_lp_e cpu_lp_encode(input logic halted,
                                              input logic stopped,
                                              input logic waiting);
        cpu_lp_e code;
        if (waiting)      code = CPU_WAITING;
        else if (stopped) code = CPU_STOPPED;
        else if (halted)  code = CPU_HALTED;
        else              code = CPU_RUN;
        return code;
    endfunction

    function automatic logic [MSG_W-1:0] msg_slice(input status_t s);
        logic [WORD_W-1:0] flat;
        flat = s;
        return flat[WORD_W-1 -: MSG_W];
    endfunction

    function automatic logic lp_entered(input status_t prev, input status_t nxt);
        logic sys_in;
        logic cpu_in;
        sys_in = (prev.sys_lp == '0) && (nxt.sys_lp != '0);
        cpu_in = (prev.cpu_lp == CPU_RUN) && (nxt.cpu_lp != CPU_RUN);
        return sys_in || cpu_in;
    endfunction

endpackage

// File: rtl/dbgstat_capture.sv
module dbgstat_capture
    import dbgstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    dbg_mode_i,
    input  logic    sys_doze_i,
    input  logic    sys_nap_i,
    input  logic    sys_sleep_i,
    input  logic    cpu_halted_i,
    input  logic    cpu_stopped_i,
    input  logic    cpu_waiting_i,
    input  logic    cpu_chkstop_i,
    output status_t status_d,
    output status_t status_q
);

    always_comb begin
        status_d        = '0;
        status_d.dbg    = dbg_mode_i;
        status_d.sys_lp = {sys_sleep_i, sys_nap_i, sys_doze_i};
        status_d.cpu_lp = cpu_lp_encode(cpu_halted_i, cpu_stopped_i, cpu_waiting_i);
        status_d.chk    = cpu_chkstop_i;
        status_d.rsvd   = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

endmodule

// File: rtl/dbgstat_trigger.sv
module dbgstat_trigger
    import dbgstat_pkg::*;
(
    input  status_t status_d,
    input  status_t status_q,
    output logic    dbg_edge_o,
    output logic    lp_entry_o,
    output logic    trig_o
);

    always_comb begin
        dbg_edge_o = status_d.dbg ^ status_q.dbg;
        lp_entry_o = lp_entered(status_q, status_d);
        trig_o     = dbg_edge_o | lp_entry_o;
    end

endmodule

// File: rtl/dbgstat_msg_slot.sv
module dbgstat_msg_slot
    import dbgstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [MSG_W-1:0] data_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [MSG_W-1:0] data_o
);

    logic take;
    assign take = valid_o & ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            data_o  <= data_i;
        end else if (take) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dbgstat_top.sv
module dbgstat_top
    import dbgstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_mode_i,
    input  logic              sys_doze_i,
    input  logic              sys_nap_i,
    input  logic              sys_sleep_i,
    input  logic              cpu_halted_i,
    input  logic              cpu_stopped_i,
    input  logic              cpu_waiting_i,
    input  logic              cpu_chkstop_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              msg_valid_o,
    input  logic              msg_ready_i,
    output logic [MSG_W-1:0]  msg_payload_o
);

    status_t status_d;
    status_t status_q;
    logic    dbg_edge;
    logic    lp_entry;
    logic    trig;

    dbgstat_capture u_capture (
        .clk           (clk),
        .rst           (rst),
        .dbg_mode_i    (dbg_mode_i),
        .sys_doze_i    (sys_doze_i),
        .sys_nap_i     (sys_nap_i),
        .sys_sleep_i   (sys_sleep_i),
        .cpu_halted_i  (cpu_halted_i),
        .cpu_stopped_i (cpu_stopped_i),
        .cpu_waiting_i (cpu_waiting_i),
        .cpu_chkstop_i (cpu_chkstop_i),
        .status_d      (status_d),
        .status_q      (status_q)
    );

    dbgstat_trigger u_trigger (
        .status_d   (status_d),
        .status_q   (status_q),
        .dbg_edge_o (dbg_edge),
        .lp_entry_o (lp_entry),
        .trig_o     (trig)
    );

    dbgstat_msg_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .load_i  (trig),
        .data_i  (msg_slice(status_d)),
        .ready_i (msg_ready_i),
        .valid_o (msg_valid_o),
        .data_o  (msg_payload_o)
    );

    assign rd_data_o = rd_en_i ? WORD_W'(status_q) : '0;

endmodule

// File: rtl/dbgstat_chk.sv
module dbgstat_chk
    import dbgstat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dbg_mode_i,
    input logic              cpu_waiting_i,
    input logic              rd_en_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              msg_valid_o,
    input logic              msg_ready_i,
    input logic [MSG_W-1:0]  msg_payload_o,
    input logic [WORD_W-1:0] status_q
);

    p_dbg_follow_r1: assert property (@(posedge clk) disable iff (rst)
        dbg_mode_i |=> status_q[WORD_W-1]);

    p_wait_prio_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_waiting_i |=> (status_q[WORD_W-1-1-SYS_W -: CPU_W] == 2'b11));

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[RSVD_W-1:0] == '0);

    p_rd_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |-> (rd_data_o == '0));

    p_dbg_edge_msg_r7: assert property (@(posedge clk) disable iff (rst)
        (status_q[WORD_W-1] != $past(status_q[WORD_W-1]))
        |-> (msg_valid_o && msg_payload_o == status_q[WORD_W-1 -: MSG_W]));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && !msg_ready_i) |=> msg_valid_o);

    p_rise_payload_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid_o) |-> (msg_payload_o == status_q[WORD_W-1 -: MSG_W]));

endmodule

bind dbgstat_top dbgstat_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .dbg_mode_i    (dbg_mode_i),
    .cpu_waiting_i (cpu_waiting_i),
    .rd_en_i       (rd_en_i),
    .rd_data_o     (rd_data_o),
    .msg_valid_o   (msg_valid_o),
    .msg_ready_i   (msg_ready_i),
    .msg_payload_o (msg_payload_o),
    .status_q      (status_q)
);

// File: tb/tb_dbgstat_top.sv
module tb_dbgstat_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg = 1'b0, doze = 1'b0, nap = 1'b0, sleep = 1'b0;
    logic        halted = 1'b0, stopped = 1'b0, waiting = 1'b0, chk = 1'b0;
    logic        rd_en = 1'b0, ready = 1'b0;
    logic [31:0] rd_data;
    logic        msg_valid;
    logic [6:0]  msg_payload;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // behavioural reference
    logic [31:0] m_status = '0;
    logic        m_valid = 1'b0;
    logic [6:0]  m_pay = '0;

    always #4 clk = ~clk;

    dbgstat_top dut (
        .clk(clk), .rst(rst),
        .dbg_mode_i(dbg), .sys_doze_i(doze), .sys_nap_i(nap), .sys_sleep_i(sleep),
        .cpu_halted_i(halted), .cpu_stopped_i(stopped), .cpu_waiting_i(waiting),
        .cpu_chkstop_i(chk), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .msg_valid_o(msg_valid), .msg_ready_i(ready), .msg_payload_o(msg_payload)
    );

    always @(posedge clk) begin
        logic [31:0] nxt;
        logic        fire;
        logic        take;
        if (rst) begin
            m_status = '0; m_valid = 1'b0; m_pay = '0;
        end else begin
            nxt = '0;
            nxt[31] = dbg;
            nxt[30] = sleep;
            nxt[29] = nap;
            nxt[28] = doze;
            if (waiting)      nxt[27:26] = 2'd3;
            else if (stopped) nxt[27:26] = 2'd2;
            else if (halted)  nxt[27:26] = 2'd1;
            nxt[25] = chk;
            fire = (nxt[31] != m_status[31])
                || (m_status[30:28] == 0 && nxt[30:28] != 0)
                || (m_status[27:26] == 0 && nxt[27:26] != 0);
            take = m_valid && ready;
            if (fire) begin
                m_valid = 1'b1;
                m_pay = nxt[31:25];
            end else if (take) begin
                m_valid = 1'b0;
            end
            m_status = nxt;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic compare_model();
        if (rd_en) begin
            check("R1", 32'(rd_data[31]), 32'(m_status[31]));
            check("R2", 32'(rd_data[30:28]), 32'(m_status[30:28]));
            check("R3", 32'(rd_data[27:26]), 32'(m_status[27:26]));
            check("R4", 32'(rd_data[25]), 32'(m_status[25]));
            check("R5", 32'(rd_data[24:0]), 32'd0);
        end else begin
            check("R6", rd_data, 32'd0);
        end
        check("R9", 32'(msg_valid), 32'(m_valid));
        if (m_valid) check("R10", 32'(msg_payload), 32'(m_pay));
    endtask

    // sys = {sleep,nap,doze}, cpu = {waiting,stopped,halted}
    task automatic step(input logic d, input logic [2:0] sys, input logic [2:0] cpu,
                        input logic c, input logic rd, input logic rdy);
        dbg = d; {sleep, nap, doze} = sys; {waiting, stopped, halted} = cpu;
        chk = c; rd_en = rd; ready = rdy;
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic expect_msg(input string req, input logic v, input logic [6:0] p);
        check(req, 32'(msg_valid), 32'(v));
        if (v) check(req, 32'(msg_payload), 32'(p));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R5 reset state
        rd_en = 1'b1;
        #1;
        check("R5", rd_data, 32'd0);
        check("R5", 32'(msg_valid), 32'd0);

        step(1, 3'b000, 3'b000, 0, 1, 0);               // debug entry
        check("R1", rd_data, 32'h8000_0000);
        expect_msg("R7", 1, 7'h40);
        step(1, 3'b000, 3'b000, 0, 1, 1);               // accept
        expect_msg("R9", 0, 7'h00);
        step(0, 3'b000, 3'b000, 0, 1, 0);               // debug exit
        expect_msg("R7", 1, 7'h00);
        step(0, 3'b000, 3'b000, 0, 1, 1);
        step(0, 3'b001, 3'b000, 0, 1, 0);               // doze entry
        check("R2", rd_data, 32'h1000_0000);
        expect_msg("R8", 1, 7'h08);
        step(0, 3'b001, 3'b000, 0, 1, 1);
        step(0, 3'b000, 3'b000, 0, 1, 0);               // exit: no message
        expect_msg("R8", 0, 7'h00);
        step(0, 3'b010, 3'b000, 0, 1, 0);               // nap entry
        expect_msg("R8", 1, 7'h10);
        step(0, 3'b110, 3'b000, 0, 1, 1);               // nonzero->nonzero, accept
        check("R2", rd_data, 32'h6000_0000);
        expect_msg("R8", 0, 7'h00);
        step(0, 3'b000, 3'b000, 0, 1, 0);
        step(0, 3'b000, 3'b111, 0, 1, 0);               // all three CPU inputs
        check("R3", rd_data, 32'h0C00_0000);
        expect_msg("R8", 1, 7'h06);
        step(0, 3'b000, 3'b011, 0, 1, 1);               // stopped+halted
        check("R3", rd_data, 32'h0800_0000);
        expect_msg("R8", 0, 7'h00);
        step(0, 3'b000, 3'b000, 1, 1, 0);               // checkstop only
        check("R4", rd_data, 32'h0200_0000);
        expect_msg("R8", 0, 7'h00);
        step(1, 3'b000, 3'b000, 1, 1, 0);
        expect_msg("R7", 1, 7'h41);
        step(1, 3'b000, 3'b001, 1, 1, 0);               // overwrite while pending
        expect_msg("R10", 1, 7'h43);
        step(0, 3'b000, 3'b001, 1, 1, 1);               // trigger + accept together
        expect_msg("R11", 1, 7'h03);
        step(0, 3'b000, 3'b001, 1, 1, 1);
        expect_msg("R9", 0, 7'h00);
        step(1, 3'b000, 3'b001, 1, 0, 0);               // strobe low
        check("R6", rd_data, 32'd0);
        expect_msg("R6", 1, 7'h43);
        step(1, 3'b000, 3'b001, 1, 1, 0);
        check("R6", rd_data, 32'h8600_0000);
        expect_msg("R9", 1, 7'h43);

        for (int i = 0; i < 4000; i++) begin
            logic [2:0] s, c;
            s = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            c = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            step(($urandom_range(0, 7) == 0) ? ~dbg : dbg, s, c,
                 1'($urandom), ($urandom_range(0, 4) != 0), 1'($urandom));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule